// File: doc/BRIEF.md
# Bus-Slave to Synchronous Memory Bridge

This block lets a simple synchronous memory sit behind a Wishbone classic slave port. When a bus request arrives (cycle and strobe both high), the bridge fires a single-cycle read or write enable toward the memory. With that enable it drives a byte address, a fixed size code and, for writes, data. One clock later it acknowledges the bus. For reads, the word the memory returns is presented on the bus in that acknowledge cycle.

The memory side has two channels, one for reads and one for writes. Each carries an enable, a byte address and a 2-bit size code, and the write channel also carries data. The size code does not depend on the transfer. It encodes the configured port granularity. The low bits of the byte address name the lowest byte lane that the select mask enables.

Write data is compacted: the bytes of the enabled lanes are packed toward bit 0 in lane order. Read data goes the other way. The memory word is taken as right-aligned, and its bytes are spread back onto the lanes the select mask enables. Lanes that are not enabled read as zero. A request that stays asserted after its acknowledge is served only once, and the master must drop it before the next request is taken.

Top module: `wb_mem_bridge`

## Requirements
- R1: In the cycle a read request (cycle, strobe high, write-enable low) is accepted, the memory read enable is 1 and the write enable is 0.
- R2: In the cycle a write request (cycle, strobe and write-enable high) is accepted, the memory write enable is 1 and the read enable is 0.
- R3: While cycle or strobe is low, both memory enables are 0 and no acknowledge is produced.
- R4: The memory byte address is the bus word address followed by the index of the lowest set select bit (2 low bits for a 32-bit bus); with no select bit set the low bits are 0.
- R5: Both size codes encode the port granularity: 8 bits gives 2'b00, 16 gives 2'b01, 32 gives 2'b10, 64 gives 2'b11 (2'b10 by default).
- R6: Memory write data holds the bytes of the selected lanes packed from bit 0 upward in ascending lane order, with all other bits 0.
- R7: The acknowledge goes high exactly one clock after the enable cycle and lasts one cycle; there is no acknowledge without a preceding enable.
- R8: A request held high after its acknowledge produces no further enable until cycle or strobe has been low for at least one clock.
- R9: During a read acknowledge, byte k of the memory read word appears on the k-th selected lane (ascending), unselected lanes are 0; outside a read acknowledge the bus read data is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wb_cyc_i | input | 1 | Bus cycle |
| wb_stb_i | input | 1 | Bus strobe |
| wb_we_i | input | 1 | Bus write enable |
| wb_adr_i | input | ADR_W | Bus word address |
| wb_sel_i | input | DATA_W/8 | Byte-lane select mask |
| wb_dat_i | input | DATA_W | Bus write data |
| wb_dat_o | output | DATA_W | Bus read data |
| wb_ack_o | output | 1 | Bus acknowledge |
| mem_rd_en_o | output | 1 | Memory read enable |
| mem_rd_addr_o | output | ADR_W+log2(DATA_W/8) | Memory read byte address |
| mem_rd_size_o | output | 2 | Memory read size code |
| mem_rd_data_i | input | DATA_W | Memory read word, right-aligned, one clock after the enable |
| mem_wr_en_o | output | 1 | Memory write enable |
| mem_wr_addr_o | output | ADR_W+log2(DATA_W/8) | Memory write byte address |
| mem_wr_size_o | output | 2 | Memory write size code |
| mem_wr_data_o | output | DATA_W | Compacted memory write data |

## Verification
The hardest case to reach from the ports is a master that keeps its request up after the acknowledge. The bench must show that no second enable is issued and that the next request is still taken once the first has dropped. The driver can hold a request for several extra cycles after the acknowledge. A free-running counter counts every enable pulse, so a request served twice shows up in the final total. Sparse and non-contiguous select masks, including an empty one, exercise lane compaction and the low address bits. The expected read data comes from a bench-side model of the memory word.

// File: rtl/wbm_bridge_pkg.sv
// Package: shared types and helpers for the bus-to-memory bridge.
// Assumes byte-wide lanes throughout.
package wbm_bridge_pkg;

    // Handshake sequencer states
    typedef enum logic [1:0] {
        HS_IDLE  = 2'd0,
        HS_ACK   = 2'd1,
        HS_DRAIN = 2'd2
    } hs_state_e;

    localparam int LANE_W = 8;

    // Encode a port granularity in bits into the 2-bit memory size code
    function automatic logic [1:0] gran_size_code(input int gran_bits);
        case (gran_bits)
            8:       return 2'b00;
            16:      return 2'b01;
            32:      return 2'b10;
            default: return 2'b11;
        endcase
    endfunction

endpackage

// File: rtl/wbm_handshake.sv
// Module: wbm_handshake
// Turns a level bus request into one enable pulse, then one acknowledge
// pulse a clock later, and waits for the request to drop before it takes
// a new one. Assumes the memory answers reads one clock after the enable.
module wbm_handshake
    import wbm_bridge_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic req_cyc,
    input  logic req_stb,
    input  logic req_we,
    output logic accept,
    output logic rd_pulse,
    output logic wr_pulse,
    output logic ack,
    output logic ack_is_read
);

    hs_state_e state_q;
    hs_state_e state_d;
    logic      req;
    logic      rd_q;

    assign req    = req_cyc && req_stb;
    assign accept = rst_n && req && (state_q == HS_IDLE);

    assign rd_pulse    = accept && !req_we;
    assign wr_pulse    = accept && req_we;
    assign ack         = (state_q == HS_ACK);
    assign ack_is_read = ack && rd_q;

    // Next-state selection for the request sequencer
    always_comb begin
        state_d = state_q;
        case (state_q)
            HS_IDLE:  if (req) state_d = HS_ACK;
            HS_ACK:   state_d = req ? HS_DRAIN : HS_IDLE;
            HS_DRAIN: if (!req) state_d = HS_IDLE;
            default:  state_d = HS_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= HS_IDLE;
        else        state_q <= state_d;
    end

    // Remember the direction of the accepted request for the ack cycle
    always_ff @(posedge clk) begin
        if (!rst_n)      rd_q <= 1'b0;
        else if (accept) rd_q <= !req_we;
    end

endmodule

// File: rtl/wbm_lane_pack.sv
// Module: wbm_lane_pack
// Packs the bytes of the selected lanes toward bit 0 in ascending lane
// order, and reports the index of the lowest selected lane (0 if none).
// Assumes at least two byte lanes.
module wbm_lane_pack
    import wbm_bridge_pkg::*;
#(
    parameter int SEL_W = 4
) (
    input  logic [SEL_W*LANE_W-1:0]  lanes_in,
    input  logic [SEL_W-1:0]         sel,
    output logic [SEL_W*LANE_W-1:0]  packed_out,
    output logic [$clog2(SEL_W)-1:0] low_lane
);

    localparam int LANE_BITS = $clog2(SEL_W);

    // Compact selected bytes downward
    always_comb begin
        int k;
        k = 0;
        packed_out = '0;
        for (int j = 0; j < SEL_W; j++) begin
            if (sel[j]) begin
                packed_out[k*LANE_W +: LANE_W] = lanes_in[j*LANE_W +: LANE_W];
                k++;
            end
        end
    end

    // Priority-encode the lowest selected lane
    always_comb begin
        low_lane = '0;
        for (int j = SEL_W - 1; j >= 0; j--) begin
            if (sel[j]) low_lane = LANE_BITS'(j);
        end
    end

endmodule

// File: rtl/wbm_lane_spread.sv
// Module: wbm_lane_spread
// Places the low bytes of a right-aligned word onto the selected lanes in
// ascending order; unselected lanes become zero.
module wbm_lane_spread
    import wbm_bridge_pkg::*;
#(
    parameter int SEL_W = 4
) (
    input  logic [SEL_W*LANE_W-1:0] packed_in,
    input  logic [SEL_W-1:0]        sel,
    output logic [SEL_W*LANE_W-1:0] lanes_out
);

    // Expand packed bytes onto enabled lanes
    always_comb begin
        int k;
        k = 0;
        lanes_out = '0;
        for (int j = 0; j < SEL_W; j++) begin
            if (sel[j]) begin
                lanes_out[j*LANE_W +: LANE_W] = packed_in[k*LANE_W +: LANE_W];
                k++;
            end
        end
    end

endmodule

// File: rtl/wb_mem_bridge.sv
// Module: wb_mem_bridge (top)
// Presents a synchronous memory with split read and write channels as a
// classic bus slave. One enable pulse per request, acknowledge one clock
// later. Assumes the memory returns right-aligned read data one clock
// after its read enable and that DATA_W is a multiple of 16.
module wb_mem_bridge
    import wbm_bridge_pkg::*;
#(
    parameter int ADR_W          = 30,
    parameter int DATA_W         = 32,
    parameter int PORT_GRAN_BITS = 32
) (
    input  logic                                 clk,
    input  logic                                 rst_n,
    input  logic                                 wb_cyc_i,
    input  logic                                 wb_stb_i,
    input  logic                                 wb_we_i,
    input  logic [ADR_W-1:0]                     wb_adr_i,
    input  logic [DATA_W/8-1:0]                  wb_sel_i,
    input  logic [DATA_W-1:0]                    wb_dat_i,
    output logic [DATA_W-1:0]                    wb_dat_o,
    output logic                                 wb_ack_o,
    output logic                                 mem_rd_en_o,
    output logic [ADR_W+$clog2(DATA_W/8)-1:0]    mem_rd_addr_o,
    output logic [1:0]                           mem_rd_size_o,
    input  logic [DATA_W-1:0]                    mem_rd_data_i,
    output logic                                 mem_wr_en_o,
    output logic [ADR_W+$clog2(DATA_W/8)-1:0]    mem_wr_addr_o,
    output logic [1:0]                           mem_wr_size_o,
    output logic [DATA_W-1:0]                    mem_wr_data_o
);

    localparam int         SEL_W      = DATA_W / LANE_W;
    localparam int         LANE_BITS  = $clog2(SEL_W);
    localparam int         BYTE_ADR_W = ADR_W + LANE_BITS;
    localparam logic [1:0] SIZE_CODE  = gran_size_code(PORT_GRAN_BITS);

    logic                  accept;
    logic                  rd_pulse;
    logic                  wr_pulse;
    logic                  ack;
    logic                  ack_rd;
    logic [SEL_W-1:0]      sel_q;
    logic [LANE_BITS-1:0]  low_lane;
    logic [DATA_W-1:0]     wr_packed;
    logic [DATA_W-1:0]     rd_spread;
    logic [BYTE_ADR_W-1:0] byte_addr;

    wbm_handshake u_hs (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_cyc     (wb_cyc_i),
        .req_stb     (wb_stb_i),
        .req_we      (wb_we_i),
        .accept      (accept),
        .rd_pulse    (rd_pulse),
        .wr_pulse    (wr_pulse),
        .ack         (ack),
        .ack_is_read (ack_rd)
    );

    wbm_lane_pack #(.SEL_W(SEL_W)) u_pack (
        .lanes_in   (wb_dat_i),
        .sel        (wb_sel_i),
        .packed_out (wr_packed),
        .low_lane   (low_lane)
    );

    wbm_lane_spread #(.SEL_W(SEL_W)) u_spread (
        .packed_in (mem_rd_data_i),
        .sel       (sel_q),
        .lanes_out (rd_spread)
    );

    // Hold the select mask of the accepted request for the read return
    always_ff @(posedge clk) begin
        if (!rst_n)      sel_q <= '0;
        else if (accept) sel_q <= wb_sel_i;
    end

    assign byte_addr = {wb_adr_i, low_lane};

    assign mem_rd_en_o   = rd_pulse;
    assign mem_rd_addr_o = byte_addr;
    assign mem_rd_size_o = SIZE_CODE;

    assign mem_wr_en_o   = wr_pulse;
    assign mem_wr_addr_o = byte_addr;
    assign mem_wr_size_o = SIZE_CODE;
    assign mem_wr_data_o = wr_packed;

    assign wb_ack_o = ack;
    assign wb_dat_o = ack_rd ? rd_spread : '0;

endmodule

// File: rtl/wbm_bridge_checker.sv
// Module: wbm_bridge_checker
// Protocol properties of the bridge, observed at its ports; bound to the top.
module wbm_bridge_checker #(
    parameter int ADR_W  = 30,
    parameter int DATA_W = 32
) (
    input logic                                 clk,
    input logic                                 rst_n,
    input logic                                 wb_cyc_i,
    input logic                                 wb_stb_i,
    input logic                                 wb_we_i,
    input logic [ADR_W-1:0]                     wb_adr_i,
    input logic [DATA_W-1:0]                    wb_dat_o,
    input logic                                 wb_ack_o,
    input logic                                 mem_rd_en_o,
    input logic [ADR_W+$clog2(DATA_W/8)-1:0]    mem_rd_addr_o,
    input logic                                 mem_wr_en_o
);

    localparam int LANE_BITS = $clog2(DATA_W / 8);

    p_rd_only_r1: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_en_o |-> (wb_cyc_i && wb_stb_i && !wb_we_i && !mem_wr_en_o));

    p_wr_only_r2: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr_en_o |-> (wb_cyc_i && wb_stb_i && wb_we_i && !mem_rd_en_o));

    p_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(wb_cyc_i && wb_stb_i) |-> (!mem_rd_en_o && !mem_wr_en_o));

    p_addr_r4: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_en_o |-> (mem_rd_addr_o[ADR_W+LANE_BITS-1:LANE_BITS] == wb_adr_i));

    p_ack_next_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd_en_o || mem_wr_en_o) |=> wb_ack_o);

    p_ack_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
        wb_ack_o |=> !wb_ack_o);

    p_ack_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
        wb_ack_o |-> $past(mem_rd_en_o || mem_wr_en_o));

    p_no_reissue_r8: assert property (@(posedge clk) disable iff (!rst_n)
        wb_ack_o |-> (!mem_rd_en_o && !mem_wr_en_o));

    p_dat_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !wb_ack_o |-> (wb_dat_o == '0));

endmodule

bind wb_mem_bridge wbm_bridge_checker #(.ADR_W(ADR_W), .DATA_W(DATA_W)) u_checker (
    .clk           (clk),
    .rst_n         (rst_n),
    .wb_cyc_i      (wb_cyc_i),
    .wb_stb_i      (wb_stb_i),
    .wb_we_i       (wb_we_i),
    .wb_adr_i      (wb_adr_i),
    .wb_dat_o      (wb_dat_o),
    .wb_ack_o      (wb_ack_o),
    .mem_rd_en_o   (mem_rd_en_o),
    .mem_rd_addr_o (mem_rd_addr_o),
    .mem_wr_en_o   (mem_wr_en_o)
);

// File: tb/wb_mem_bridge_test.sv
`timescale 1ns/100ps
// Scoreboard bench: the driver pushes the expected bus read result of each
// access; a monitor pops one entry per acknowledge and compares.
module wb_mem_bridge_test;

    localparam int ADR_W  = 30;
    localparam int DATA_W = 32;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cyc = 1'b0, stb = 1'b0, we = 1'b0;
    logic [ADR_W-1:0]  adr = '0;
    logic [3:0]        sel = '0;
    logic [31:0]       wdat = '0;
    logic [31:0]       rdat_bus;
    logic              ack;
    logic              rd_en, wr_en;
    logic [31:0]       rd_addr, wr_addr;
    logic [1:0]        rd_size, wr_size;
    logic [31:0]       mem_q = '0;
    logic [31:0]       wr_data;

    int checks = 0;
    int errors = 0;
    int en_count = 0;
    int accesses = 0;
    logic [31:0] sb_q[$];

    always #2.5 clk = ~clk;

    wb_mem_bridge uut (
        .clk(clk), .rst_n(rst_n),
        .wb_cyc_i(cyc), .wb_stb_i(stb), .wb_we_i(we),
        .wb_adr_i(adr), .wb_sel_i(sel), .wb_dat_i(wdat),
        .wb_dat_o(rdat_bus), .wb_ack_o(ack),
        .mem_rd_en_o(rd_en), .mem_rd_addr_o(rd_addr), .mem_rd_size_o(rd_size),
        .mem_rd_data_i(mem_q),
        .mem_wr_en_o(wr_en), .mem_wr_addr_o(wr_addr), .mem_wr_size_o(wr_size),
        .mem_wr_data_o(wr_data)
    );

    // Memory model word, a function of the byte address
    function automatic logic [31:0] mem_fn(input logic [31:0] a);
        return {a[7:0] ^ 8'h3C, a[7:0] ^ 8'h5A, a[7:0] + 8'd7, ~a[7:0]};
    endfunction

    // Expected bus view of a right-aligned word under a select mask
    function automatic logic [31:0] spread_ref(input logic [31:0] w, input logic [3:0] s);
        logic [31:0] r;
        int k;
        r = '0;
        k = 0;
        for (int j = 0; j < 4; j++) begin
            if (s[j]) begin
                r[j*8 +: 8] = w[k*8 +: 8];
                k++;
            end
        end
        return r;
    endfunction

    always @(posedge clk) begin
        if (rd_en) mem_q <= mem_fn(rd_addr);
        if (rst_n && (rd_en || wr_en)) en_count++;
    end

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Monitor: one scoreboard entry per acknowledge
    initial begin
        forever begin
            @(negedge clk);
            #1;
            if (ack) begin
                if (sb_q.size() == 0) begin
                    chk("R7 unexpected ack", 1, 0);
                end else begin
                    logic [31:0] e;
                    e = sb_q.pop_front();
                    chk("R9 read data", rdat_bus, e);
                end
            end
        end
    end

    // Driver: one access, optional extra hold after the acknowledge
    task automatic access(input logic w, input logic [ADR_W-1:0] a, input logic [3:0] s,
                          input logic [31:0] d, input logic [1:0] exp_low,
                          input logic [31:0] exp_wdata, input int hold);
        logic [31:0] ba;
        @(negedge clk);
        cyc = 1'b1; stb = 1'b1; we = w; adr = a; sel = s; wdat = d;
        ba = {a, exp_low};
        accesses++;
        #0.5;
        if (w) begin
            chk("R2 write enable", wr_en, 1);
            chk("R2 read enable low", rd_en, 0);
            chk("R4 write address", wr_addr, ba);
            chk("R5 write size", wr_size, 2'b10);
            chk("R6 write data", wr_data, exp_wdata);
            sb_q.push_back(32'h0);
        end else begin
            chk("R1 read enable", rd_en, 1);
            chk("R1 write enable low", wr_en, 0);
            chk("R4 read address", rd_addr, ba);
            chk("R5 read size", rd_size, 2'b10);
            sb_q.push_back(spread_ref(mem_fn(ba), s));
        end
        @(negedge clk);
        #0.5;
        chk("R7 ack after one clock", ack, 1);
        chk("R8 no enable in ack cycle", {rd_en, wr_en}, 0);
        for (int i = 0; i < hold; i++) begin
            @(negedge clk);
            #0.5;
            chk("R7 ack single pulse", ack, 0);
            chk("R8 held request not reissued", {rd_en, wr_en}, 0);
        end
        @(negedge clk);
        cyc = 1'b0; stb = 1'b0;
        #0.5;
        chk("R3 idle enables", {rd_en, wr_en, ack}, 0);
    endtask

    initial begin
        #250000;
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #0.5;
        chk("R3 reset ack", ack, 0);
        chk("R3 reset enables", {rd_en, wr_en}, 0);
        chk("R9 reset read data", rdat_bus, 0);

        // Writes: compaction and low address bits
        access(1'b1, 30'h0000_0004, 4'b1111, 32'hDEAD_BEEF, 2'd0, 32'hDEAD_BEEF, 0);
        access(1'b1, 30'h0000_0011, 4'b0100, 32'h1122_3344, 2'd2, 32'h0000_0022, 0);
        access(1'b1, 30'h0000_0012, 4'b1100, 32'hAABB_CCDD, 2'd2, 32'h0000_AABB, 1);
        access(1'b1, 30'h0000_0013, 4'b0110, 32'h1234_5678, 2'd1, 32'h0000_3456, 0);
        access(1'b1, 30'h0000_0014, 4'b1000, 32'h9A00_0000, 2'd3, 32'h0000_009A, 0);
        access(1'b1, 30'h0000_0015, 4'b0101, 32'hF0E1_D2C3, 2'd0, 32'h0000_E1C3, 0);
        access(1'b1, 30'h0000_0016, 4'b0000, 32'hFFFF_FFFF, 2'd0, 32'h0000_0000, 0);

        // Reads: spreading back onto lanes
        access(1'b0, 30'h0000_0010, 4'b1111, 32'h0, 2'd0, 32'h0, 0);
        access(1'b0, 30'h0000_0021, 4'b0010, 32'h0, 2'd1, 32'h0, 0);
        access(1'b0, 30'h0000_0003, 4'b1100, 32'h0, 2'd2, 32'h0, 3);
        access(1'b0, 30'h3FFF_FFFF, 4'b1001, 32'h0, 2'd0, 32'h0, 0);
        access(1'b0, 30'h0000_0042, 4'b0001, 32'h0, 2'd0, 32'h0, 5);

        // Half requests must not start anything
        @(negedge clk);
        cyc = 1'b0; stb = 1'b1; we = 1'b0;
        #0.5;
        chk("R3 strobe without cycle", {rd_en, wr_en}, 0);
        @(negedge clk);
        #0.5;
        chk("R3 no ack for strobe only", ack, 0);
        cyc = 1'b1; stb = 1'b0; we = 1'b1;
        #0.5;
        chk("R3 cycle without strobe", {rd_en, wr_en}, 0);
        @(negedge clk);
        #0.5;
        chk("R3 no ack for cycle only", ack, 0);
        cyc = 1'b0;

        repeat (3) @(negedge clk);
        #2;
        chk("R7 every access acknowledged", sb_q.size(), 0);
        chk("R8 one enable per access", en_count, accesses);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule